// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block watches the bytes of each received Ethernet frame as they arrive and decides, once per frame, whether the frame should be time-stamped by the capture unit. It parses the Ethernet header, an optional single 802.1Q tag, an IPv4 header of any legal length and a UDP header. It then reads the first bytes of the precision time protocol header and, for version 1, the control byte. A three-bit filter mode chooses which frames count: none, version-1 Sync over UDP, version-1 Delay_Req over UDP, any version-2 event message over Ethernet or UDP, or every frame.

The byte stream carries a valid strobe and a start-of-frame marker on the first byte. The decision is registered. It appears in the clock cycle after the last byte it depends on, and it stays until the next start of frame. A one-cycle stamp request goes out only when the frame is to be stamped. A frame that ends before its deciding byte produces no decision.

Top module: `ptp_event_classifier`

## Requirements
- R1: While reset is asserted and after its release, before any frame, `decided`, `stamp_hit` and `stamp_req` are 0.
- R2: In mode 0 (off) and in the reserved mode 7, every frame is decided at its first byte with `stamp_hit` = 0 and no stamp request.
- R3: In mode 6 (all frames), every frame is decided as a hit at its first byte. `stamp_req` is high in the cycle after that byte is accepted.
- R4: In the version-2 modes, a frame whose ethertype (bytes 12..13, big-endian) is 0x88F7 is a hit only if the message type is 0 to 3 and the version is 2. The message type is the low nibble of time header byte 0 and the version is the low nibble of time header byte 1. The header starts right after the ethertype. The decision comes in the cycle after header byte 1.
- R5: A single tag with TPID 0x8100 at bytes 12..13 moves the ethertype to bytes 16..17 and the payload 4 bytes later. A second 0x8100 tag makes the frame a miss.
- R6: Over IPv4 (ethertype 0x0800), a frame matches only if the IP version nibble is 4, IHL is at least 5 and the protocol byte (IP offset 9) is 17. The UDP destination port (UDP offset 2..3, big-endian) must be 319. The UDP header starts 4*IHL bytes into the IP header and the time header 8 bytes after that. The same version and message checks as R4 apply in the version-2 modes.
- R7: With `cfg_src_port_chk` = 1, the UDP source port (UDP offset 0..1) must also be 319. With it at 0, the source port has no effect.
- R8: Mode 1 stamps only UDP frames with version 1 whose control byte (time header offset 32) is 0. A version other than 1 is a miss.
- R9: Mode 2 stamps only UDP frames with version 1 whose control byte is 1.
- R10: Modes 4 and 5 behave exactly as mode 3: all version-2 event messages are stamped, not only Sync or Delay_Req.
- R11: At most one `stamp_req` pulse occurs per frame. `decided` and `stamp_hit` hold until the next start of frame, and a frame cut short before its deciding byte leaves `decided` at 0.
- R12: A frame whose ethertype is neither the time ethertype nor IPv4 is a miss in every filtering mode. In modes 1 and 2, frames that use the Ethernet time ethertype are a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A byte is present on `in_data` this cycle |
| in_sof | input | 1 | Marks the first byte of a frame (qualified by `in_vld`) |
| in_data | input | 8 | Frame byte, in wire order |
| cfg_mode | input | 3 | Filter mode: 0 off, 1 v1 Sync, 2 v1 Delay_Req, 3 v2 event, 4 v2 Sync (widened), 5 v2 Delay_Req (widened), 6 all, 7 reserved |
| cfg_src_port_chk | input | 1 | Also require UDP source port 319 |
| stamp_req | output | 1 | One-cycle request to capture a time stamp for this frame |
| stamp_hit | output | 1 | Held decision: frame is to be stamped |
| decided | output | 1 | Held: the current frame has been decided |

## Verification
The checker assumes that `cfg_mode` and `cfg_src_port_chk` stay constant from a start of frame until that frame's decision. It also assumes that `in_sof` is only meaningful together with `in_vld`. The bench changes the configuration only while the stream is idle between frames, and it raises `in_sof` only with the first valid byte. Some frames are sent with idle gaps inside them, to show that parsing counts valid bytes rather than cycles. Frames cut short before their deciding byte are followed at once by a new start of frame, which the properties on held decisions allow.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

    typedef enum logic [2:0] {
        MODE_OFF      = 3'd0,
        MODE_V1_SYNC  = 3'd1,
        MODE_V1_DREQ  = 3'd2,
        MODE_V2_EVENT = 3'd3,
        MODE_V2_SYNC  = 3'd4,
        MODE_V2_DREQ  = 3'd5,
        MODE_ALL      = 3'd6,
        MODE_RSVD     = 3'd7
    } flt_mode_e;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_L2   = 2'd1,
        PK_IP   = 2'd2
    } pay_kind_e;

    typedef struct packed {
        logic       off;
        logic       all;
        logic       l2_en;
        logic       l4_en;
        logic       v1;
        logic [7:0] v1_ctrl;
    } flt_cfg_t;

endpackage

// File: rtl/ptp_cls_mode_dec.sv
module ptp_cls_mode_dec
    import ptp_cls_pkg::*;
(
    input  logic [2:0] mode,
    output flt_cfg_t   cfg
);

    always_comb begin
        cfg = '0;
        case (flt_mode_e'(mode))
            MODE_V1_SYNC: begin
                cfg.l4_en   = 1'b1;
                cfg.v1      = 1'b1;
                cfg.v1_ctrl = 8'd0;
            end
            MODE_V1_DREQ: begin
                cfg.l4_en   = 1'b1;
                cfg.v1      = 1'b1;
                cfg.v1_ctrl = 8'd1;
            end
            MODE_V2_EVENT, MODE_V2_SYNC, MODE_V2_DREQ: begin
                // narrow version-2 requests are widened to every event type
                cfg.l2_en = 1'b1;
                cfg.l4_en = 1'b1;
            end
            MODE_ALL: cfg.all = 1'b1;
            default:  cfg.off = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptp_cls_byte_idx.sv
module ptp_cls_byte_idx #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_sof,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] IDX_SAT = '1;

    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        idx   = (in_vld && in_sof) ? '0 : cnt_q;
        cnt_d = cnt_q;
        if (in_vld) begin
            cnt_d = (idx == IDX_SAT) ? idx : idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier
    import ptp_cls_pkg::*;
#(
    parameter int          IDX_W      = 8,
    parameter logic [15:0] PTP_ETYPE  = 16'h88F7,
    parameter logic [15:0] VLAN_TPID  = 16'h8100,
    parameter logic [15:0] IPV4_ETYPE = 16'h0800,
    parameter logic [7:0]  UDP_PROTO  = 8'd17,
    parameter logic [15:0] EVENT_PORT = 16'd319,
    parameter int          V1_CTRL_AT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_vld,
    input  logic       in_sof,
    input  logic [7:0] in_data,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_src_port_chk,
    output logic       stamp_req,
    output logic       stamp_hit,
    output logic       decided
);

    localparam logic [IDX_W-1:0] ETYPE_AT  = IDX_W'(12);
    localparam logic [IDX_W-1:0] TAG_LEN   = IDX_W'(4);
    localparam logic [IDX_W-1:0] ETYPE_LEN = IDX_W'(2);
    localparam logic [IDX_W-1:0] UDP_LEN   = IDX_W'(8);
    localparam logic [IDX_W-1:0] CTRL_OFS  = IDX_W'(V1_CTRL_AT);
    localparam logic [IDX_W-1:0] IP_PROTO  = IDX_W'(9);
    localparam logic [IDX_W-1:0] ONE       = IDX_W'(1);
    localparam logic [IDX_W-1:0] NOWHERE   = '1;

    typedef struct packed {
        logic             act;
        logic             done;
        logic             hit;
        logic             req;
        logic             tag_seen;
        pay_kind_e        kind;
        logic [7:0]       hold;
        logic [3:0]       msg;
        logic [IDX_W-1:0] eth_ofs;
        logic [IDX_W-1:0] pay_ofs;
        logic [IDX_W-1:0] udp_ofs;
        logic [IDX_W-1:0] ptp_ofs;
    } st_t;

    flt_cfg_t         cfg;
    logic [IDX_W-1:0] idx;
    st_t              st_d, st_q;

    ptp_cls_mode_dec u_mode_dec (
        .mode (cfg_mode),
        .cfg  (cfg)
    );

    ptp_cls_byte_idx #(.IDX_W(IDX_W)) u_byte_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .in_sof (in_sof),
        .idx    (idx)
    );

    always_comb begin
        st_t         c;
        logic        fin;
        logic        good;
        logic [15:0] word;

        c    = st_q;
        fin  = 1'b0;
        good = 1'b0;
        word = {st_q.hold, in_data};

        if (in_vld && in_sof) begin
            c.act      = 1'b1;
            c.done     = 1'b0;
            c.hit      = 1'b0;
            c.tag_seen = 1'b0;
            c.kind     = PK_NONE;
            c.eth_ofs  = ETYPE_AT;
            c.pay_ofs  = NOWHERE;
            c.udp_ofs  = NOWHERE;
            c.ptp_ofs  = NOWHERE;
        end

        st_d     = c;
        st_d.req = 1'b0;

        if (in_vld && c.act) begin
            // mode-only decisions on the first byte
            if (idx == '0) begin
                if (cfg.off) begin
                    fin = 1'b1;
                end else if (cfg.all) begin
                    fin  = 1'b1;
                    good = 1'b1;
                end
            end

            // ethertype, possibly behind one tag
            if (idx == c.eth_ofs) st_d.hold = in_data;
            if (idx == c.eth_ofs + ONE) begin
                if (word == VLAN_TPID && !c.tag_seen) begin
                    st_d.tag_seen = 1'b1;
                    st_d.eth_ofs  = c.eth_ofs + TAG_LEN;
                end else if (word == PTP_ETYPE && cfg.l2_en) begin
                    st_d.kind    = PK_L2;
                    st_d.pay_ofs = c.eth_ofs + ETYPE_LEN;
                    st_d.ptp_ofs = c.eth_ofs + ETYPE_LEN;
                end else if (word == IPV4_ETYPE && cfg.l4_en) begin
                    st_d.kind    = PK_IP;
                    st_d.pay_ofs = c.eth_ofs + ETYPE_LEN;
                end else begin
                    fin = 1'b1;
                end
            end

            // IPv4 and UDP headers
            if (c.kind == PK_IP) begin
                if (idx == c.pay_ofs) begin
                    if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) begin
                        fin = 1'b1;
                    end else begin
                        st_d.udp_ofs = c.pay_ofs + IDX_W'({in_data[3:0], 2'b00});
                        st_d.ptp_ofs = c.pay_ofs + IDX_W'({in_data[3:0], 2'b00}) + UDP_LEN;
                    end
                end
                if (idx == c.pay_ofs + IP_PROTO && in_data != UDP_PROTO) fin = 1'b1;
                if (idx == c.udp_ofs) st_d.hold = in_data;
                if (idx == c.udp_ofs + ONE && cfg_src_port_chk && word != EVENT_PORT) fin = 1'b1;
                if (idx == c.udp_ofs + IDX_W'(2)) st_d.hold = in_data;
                if (idx == c.udp_ofs + IDX_W'(3) && word != EVENT_PORT) fin = 1'b1;
            end

            // time header
            if (c.kind != PK_NONE) begin
                if (idx == c.ptp_ofs) st_d.msg = in_data[3:0];
                if (idx == c.ptp_ofs + ONE) begin
                    if (cfg.v1) begin
                        if (in_data[3:0] != 4'd1) fin = 1'b1;
                    end else begin
                        fin  = 1'b1;
                        good = (in_data[3:0] == 4'd2) && (c.msg < 4'd4);
                    end
                end
                if (cfg.v1 && idx == c.ptp_ofs + CTRL_OFS) begin
                    fin  = 1'b1;
                    good = (in_data == cfg.v1_ctrl);
                end
            end

            if (fin) begin
                st_d.act  = 1'b0;
                st_d.done = 1'b1;
                st_d.hit  = good;
                st_d.req  = good;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_req = st_q.req;
    assign stamp_hit = st_q.hit;
    assign decided   = st_q.done;

endmodule

// File: rtl/ptp_cls_chk.sv
module ptp_cls_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_vld,
    input logic       in_sof,
    input logic [2:0] cfg_mode,
    input logic       stamp_req,
    input logic       stamp_hit,
    input logic       decided
);

    a_r11_req_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_req |-> stamp_hit && decided);

    a_r11_hit_needs_decision: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_hit |-> decided);

    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_req && !(in_vld && in_sof) |=> !stamp_req);

    a_r11_decision_held: assert property (@(posedge clk) disable iff (!rst_n)
        decided && !(in_vld && in_sof) |=> decided && $stable(stamp_hit));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !stamp_req && $stable(decided));

    a_r2_off_misses: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && in_sof && (cfg_mode == 3'd0 || cfg_mode == 3'd7) |=> decided && !stamp_hit);

    a_r3_all_hits: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && in_sof && cfg_mode == 3'd6 |=> stamp_req);

endmodule

bind ptp_event_classifier ptp_cls_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_sof    (in_sof),
    .cfg_mode  (cfg_mode),
    .stamp_req (stamp_req),
    .stamp_hit (stamp_hit),
    .decided   (decided)
);

// File: tb/ptp_event_classifier_bench.sv
module ptp_event_classifier_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [2:0] cfg_mode = 3'd0;
    logic       cfg_src_port_chk = 1'b0;
    logic       stamp_req, stamp_hit, decided;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    ptp_event_classifier u_ptp_event_classifier (
        .clk              (clk),
        .rst_n            (rst_n),
        .in_vld           (in_vld),
        .in_sof           (in_sof),
        .in_data          (in_data),
        .cfg_mode         (cfg_mode),
        .cfg_src_port_chk (cfg_src_port_chk),
        .stamp_req        (stamp_req),
        .stamp_hit        (stamp_hit),
        .decided          (decided)
    );

    // kind: 0 other ethertype, 1 time ethertype, 2 IPv4/UDP
    typedef struct packed {
        logic [2:0]  mode;
        logic        schk;
        logic [1:0]  tags;
        logic [1:0]  kind;
        logic [3:0]  ihl;
        logic [7:0]  proto;
        logic [15:0] sport;
        logic [15:0] dport;
        logic [3:0]  msg;
        logic [3:0]  ver;
        logic [7:0]  ctrl;
        logic        hit;
        logic [7:0]  req_no;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [0:NV-1] = '{
        '{3'd3, 1'b0, 2'd0, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b1, 8'd4},  // R4 Sync
        '{3'd3, 1'b0, 2'd0, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd8, 4'd2, 8'd0, 1'b0, 8'd4},  // R4 general msg
        '{3'd3, 1'b0, 2'd0, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd3, 4'd1, 8'd0, 1'b0, 8'd4},  // R4 wrong version
        '{3'd3, 1'b0, 2'd1, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd3, 4'd2, 8'd0, 1'b1, 8'd5},  // R5 one tag
        '{3'd3, 1'b0, 2'd2, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd5},  // R5 two tags
        '{3'd3, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd1, 4'd2, 8'd0, 1'b1, 8'd6},  // R6 UDP event
        '{3'd3, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd320, 4'd1, 4'd2, 8'd0, 1'b0, 8'd6},  // R6 port 320
        '{3'd3, 1'b0, 2'd0, 2'd2, 4'd7, 8'd17, 16'd319, 16'd319, 4'd2, 4'd2, 8'd0, 1'b1, 8'd6},  // R6 options
        '{3'd3, 1'b0, 2'd0, 2'd2, 4'd5, 8'd6,  16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd6},  // R6 not UDP
        '{3'd3, 1'b0, 2'd0, 2'd2, 4'd4, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd6},  // R6 bad IHL
        '{3'd3, 1'b1, 2'd0, 2'd2, 4'd5, 8'd17, 16'd1000, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd7}, // R7 src checked
        '{3'd3, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd1000, 16'd319, 4'd0, 4'd2, 8'd0, 1'b1, 8'd7}, // R7 src ignored
        '{3'd3, 1'b1, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b1, 8'd7},  // R7 src matches
        '{3'd1, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'd0, 1'b1, 8'd8},  // R8 v1 Sync
        '{3'd1, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'd1, 1'b0, 8'd8},  // R8 v1 Delay_Req
        '{3'd1, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd8},  // R8 version 2
        '{3'd2, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'd1, 1'b1, 8'd9},  // R9 v1 Delay_Req
        '{3'd2, 1'b0, 2'd1, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'd0, 1'b0, 8'd9},  // R9 Sync miss
        '{3'd4, 1'b0, 2'd0, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd1, 4'd2, 8'd0, 1'b1, 8'd10}, // R10 widened
        '{3'd5, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b1, 8'd10}, // R10 widened
        '{3'd3, 1'b0, 2'd0, 2'd0, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd12}, // R12 other etype
        '{3'd1, 1'b0, 2'd0, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd1, 8'd0, 1'b0, 8'd12}, // R12 L2 in v1 mode
        '{3'd0, 1'b0, 2'd0, 2'd1, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd2},  // R2 off
        '{3'd7, 1'b0, 2'd0, 2'd2, 4'd5, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2, 8'd0, 1'b0, 8'd2}   // R2 reserved
    };

    logic [7:0] fb [0:191];
    int         flen;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        fb[flen] = b;
        flen++;
    endtask

    task automatic build(input vec_t v);
        flen = 0;
        for (int i = 0; i < 6; i++) put(8'h10 + 8'(i));
        for (int i = 0; i < 6; i++) put(8'h40 + 8'(i));
        for (int t = 0; t < int'(v.tags); t++) begin
            put(8'h81); put(8'h00); put(8'h00); put(8'h07 + 8'(t));
        end
        case (v.kind)
            2'd1: begin put(8'h88); put(8'hF7); end
            2'd2: begin put(8'h08); put(8'h00); end
            default: begin put(8'h08); put(8'h06); end
        endcase
        if (v.kind == 2'd0) begin
            for (int i = 0; i < 40; i++) put(8'hA5);
        end else begin
            if (v.kind == 2'd2) begin
                put({4'h4, v.ihl});
                for (int i = 1; i < 9; i++) put(8'h00);
                put(v.proto);
                for (int i = 10; i < 4 * int'(v.ihl) || i < 20; i++) put(8'h11);
                put(v.sport[15:8]); put(v.sport[7:0]);
                put(v.dport[15:8]); put(v.dport[7:0]);
                put(8'h00); put(8'h40); put(8'h00); put(8'h00);
            end
            for (int i = 0; i < 44; i++) begin
                if (i == 0)       put({4'h0, v.msg});
                else if (i == 1)  put({4'h0, v.ver});
                else if (i == 32) put(v.ctrl);
                else              put(8'h00);
            end
        end
    endtask

    // Sends fb[0..cut-1]; gaps inserts an idle cycle every fourth step.
    task automatic send(input int cut, input bit gaps, input int idle,
                        output int nreq, output int first_req);
        int p;
        int step;
        p = 0;
        step = 0;
        nreq = 0;
        first_req = -1;
        while (p < cut) begin
            @(negedge clk);
            if (stamp_req) begin
                nreq++;
                if (first_req < 0) first_req = step;
            end
            if (gaps && (step % 4) == 3) begin
                in_vld = 1'b0;
                in_sof = 1'b0;
            end else begin
                in_vld  = 1'b1;
                in_sof  = (p == 0);
                in_data = fb[p];
                p++;
            end
            step++;
        end
        for (int k = 0; k < idle; k++) begin
            @(negedge clk);
            if (stamp_req) begin
                nreq++;
                if (first_req < 0) first_req = step;
            end
            in_vld = 1'b0;
            in_sof = 1'b0;
            step++;
        end
    endtask

    task automatic set_cfg(input logic [2:0] m, input logic s);
        @(negedge clk);
        in_vld = 1'b0;
        in_sof = 1'b0;
        cfg_mode = m;
        cfg_src_port_chk = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int  nreq;
        int  first;
        vec_t v;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(decided == 1'b0 && stamp_hit == 1'b0 && stamp_req == 1'b0, "R1 in reset",
              int'({decided, stamp_hit, stamp_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(decided == 1'b0 && stamp_hit == 1'b0 && stamp_req == 1'b0, "R1 after reset",
              int'({decided, stamp_hit, stamp_req}), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            set_cfg(v.mode, v.schk);
            build(v);
            send(flen, (i % 2) == 1, 4, nreq, first);
            check(stamp_hit == v.hit, $sformatf("R%0d vector %0d hit", v.req_no, i),
                  int'(stamp_hit), int'(v.hit));
            check(nreq == int'(v.hit), $sformatf("R%0d vector %0d request count", v.req_no, i),
                  nreq, int'(v.hit));
            check(decided == 1'b1, "R11 decision held after frame", int'(decided), 1);
        end

        // R4: gapless version-2 over Ethernet, decision after header byte 1 (frame byte 15)
        v = VECS[0];
        set_cfg(v.mode, v.schk);
        build(v);
        send(flen, 1'b0, 3, nreq, first);
        check(first == 16, "R4 decision cycle", first, 16);

        // R3: all mode requests right after the first byte
        v = VECS[20];
        v.mode = 3'd6;
        set_cfg(v.mode, 1'b0);
        build(v);
        send(flen, 1'b0, 3, nreq, first);
        check(first == 1, "R3 decision cycle", first, 1);
        check(nreq == 1 && stamp_hit == 1'b1, "R3 single hit", nreq, 1);

        // R8: control byte at frame byte 74 for IHL 5 without tags
        v = VECS[13];
        set_cfg(v.mode, v.schk);
        build(v);
        send(flen, 1'b0, 3, nreq, first);
        check(first == 75, "R8 decision cycle", first, 75);

        // R11: truncated frame leaves no decision, next frame still classified
        v = VECS[5];
        set_cfg(v.mode, v.schk);
        build(v);
        send(30, 1'b0, 3, nreq, first);
        check(decided == 1'b0 && nreq == 0, "R11 truncated frame", int'(decided) + nreq, 0);
        send(flen, 1'b0, 3, nreq, first);
        check(stamp_hit == 1'b1 && nreq == 1, "R11 frame after truncation", nreq, 1);

        // R11: a truncated frame immediately followed by a new start of frame
        send(20, 1'b0, 0, nreq, first);
        send(flen, 1'b1, 3, nreq, first);
        check(stamp_hit == 1'b1 && nreq == 1, "R11 back-to-back restart", nreq, 1);

        // R11: idle cycles after a decision keep it
        repeat (10) @(negedge clk);
        check(decided == 1'b1 && stamp_hit == 1'b1 && stamp_req == 1'b0, "R11 long hold",
              int'({decided, stamp_hit, stamp_req}), 6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule